// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a virtual address into a physical address by reading page table entries from memory, one level at a time. It starts at the top level, using the root page number given on a separate input, and moves down until it finds a leaf entry or a fault. A single parameter chooses between two geometries. The first has two levels, 4-byte entries and 10-bit index fields. The second has three levels, 8-byte entries and 9-bit index fields. Both use 4 KiB pages.

A requester hands over a virtual address, an access kind and a user-privilege flag through a valid/ready handshake. The walker then issues entry reads on a request/grant memory port. When the leaf entry's accessed or dirty flag has to be set, it also writes the entry back. The memory answers each transfer with a response strobe and an error bit, and the error bit carries the outcome of the physical protection checks. The walker holds a lock output around each entry read, and keeps it held through any write-back that follows, so the read-modify-write of an entry cannot be split by another store.

The result is returned on a second valid/ready handshake. It carries a one-hot outcome: success, page fault or access fault. On success it also carries the physical address.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted, and until a request arrives, `req_ready` is 1 and `rsp_valid`, `mem_req` and `mem_lock` are 0.
- R2: The first read goes to root_ppn·4096 + VPN[top]·PTE bytes. Each later read goes to ppn·4096 + VPN[level]·PTE bytes, where ppn comes from the pointer entry just read. A walk makes exactly one read per level it visits.
- R3: Entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, with the page number starting at bit 10. An entry with V=0, or with W=1 and R=0, ends the walk with a page fault.
- R4: A valid entry with R=1 or X=1 is a leaf. Any other valid entry is a pointer. A pointer found at level 0 gives a page fault.
- R5: Access kind 1 is a store and needs W=1. Kind 2 is a fetch and needs X=1. Kinds 0 and 3 are loads and need R=1. A user request needs U=1, and a supervisor request needs U=0. A violation gives a page fault and no write-back.
- R6: A permitted leaf with A=0, or a store to a leaf with D=0, is written back to its own address. The written value is the entry with A set, and with D also set for a store. No write-back happens otherwise.
- R7: A memory response with the error bit set, whether to an entry read or to the write-back, ends the walk with an access fault.
- R8: `mem_lock` is 1 for every cycle of a memory request and while its response is awaited. It does not drop between a leaf read's response and the end of that leaf's write-back. A request held without grant keeps its address and direction.
- R9: On success, `rsp_pa` is the leaf page number followed by the 12-bit page offset. For a leaf found at level L>0, the low L index fields of the virtual address replace the low L page number fields. On a fault `rsp_pa` is 0.
- R10: `rsp_outcome` has success at bit 0, page fault at bit 1 and access fault at bit 2. Exactly one bit is set while `rsp_valid` is 1. The outcome and address stay stable until `rsp_ready`. `req_ready` stays 0 from the moment a request is accepted until its result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | VA_W (32/39) | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_user | input | 1 | 1 for a user-privilege access |
| root_ppn | input | PPN_W (22/44) | Page number of the top-level table |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_pa | output | PA_W (34/56) | Physical address, 0 on fault |
| rsp_outcome | output | 3 | One-hot: bit 0 success, bit 1 page fault, bit 2 access fault |
| mem_req | output | 1 | Memory transfer request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 for the write-back, 0 for an entry read |
| mem_addr | output | PA_W | Byte address of the entry |
| mem_wdata | output | PTE_W (32/64) | Entry value to write back |
| mem_lock | output | 1 | Keeps other stores off the entry |
| mem_rvalid | input | 1 | Response strobe for the granted transfer |
| mem_rdata | input | PTE_W | Entry value read |
| mem_err | input | 1 | Protection or memory error on this transfer |

## Verification
Two things can happen in the same cycle: a finished result waits for `rsp_ready`, and a new request is already sitting on `req_valid`. The bench sets this up by holding `rsp_ready` low over several cycles while a second request is offered. Each of those cycles it checks that `req_ready` stays low and that the pending outcome and address do not move. It then releases `rsp_ready` and confirms that the queued request is accepted and translated correctly. A second overlap comes from the memory side: the grant is held off while the lock and a write-back request are both pending. The bench judges this by the final memory contents and by a count of requests issued without the lock.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int OFS_W   = 12;
   localparam int PPN_LSB = 10;

   localparam int B_V = 0;
   localparam int B_R = 1;
   localparam int B_W = 2;
   localparam int B_X = 3;
   localparam int B_U = 4;
   localparam int B_A = 6;
   localparam int B_D = 7;

   localparam int OUT_OK = 0;
   localparam int OUT_PF = 1;
   localparam int OUT_AF = 2;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_LOAD2 = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_REQ  = 3'd1,
      ST_RD_WAIT = 3'd2,
      ST_WB_REQ  = 3'd3,
      ST_WB_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_st_e;
endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
   import ptw_pkg::*;
#(
   parameter int PTE_W = 32
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [1:0]       kind,
   input  logic             user,
   output logic             invalid,
   output logic             leaf,
   output logic             perm_fault,
   output logic             need_upd,
   output logic [PTE_W-1:0] upd_pte
);
   logic is_store;
   logic is_fetch;
   logic rights;

   always_comb begin
      is_store = (kind == ACC_STORE);
      is_fetch = (kind == ACC_FETCH);
      invalid  = !pte[B_V] || (pte[B_W] && !pte[B_R]);
      leaf     = pte[B_R] || pte[B_X];
      if (is_store)      rights = pte[B_W];
      else if (is_fetch) rights = pte[B_X];
      else               rights = pte[B_R];
      perm_fault = !rights || (pte[B_U] != user);
      need_upd   = !pte[B_A] || (is_store && !pte[B_D]);
      upd_pte         = pte;
      upd_pte[B_A]    = 1'b1;
      if (is_store) upd_pte[B_D] = 1'b1;
   end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
   import ptw_pkg::*;
#(
   parameter int LEVELS    = 2,
   parameter int VPN_W     = 10,
   parameter int PPN_W     = 22,
   parameter int PTE_BYTES = 4,
   localparam int VA_W  = OFS_W + LEVELS * VPN_W,
   localparam int PA_W  = OFS_W + PPN_W,
   localparam int LVL_W = $clog2(LEVELS),
   localparam int SH    = $clog2(PTE_BYTES),
   localparam int TOP_LSB = (LEVELS - 1) * VPN_W
) (
   input  logic [VA_W-1:0]  va,
   input  logic [PPN_W-1:0] base_ppn,
   input  logic [LVL_W-1:0] lvl,
   input  logic [PPN_W-1:0] leaf_ppn,
   output logic [PA_W-1:0]  pte_addr,
   output logic [PA_W-1:0]  leaf_pa
);
   logic [VPN_W-1:0] vpn [LEVELS];
   logic [VPN_W-1:0] vpn_sel;
   logic [PPN_W-1:0] pa_ppn;

   for (genvar g = 0; g < LEVELS; g++) begin : g_vpn
      assign vpn[g] = va[OFS_W + g*VPN_W +: VPN_W];
   end

   always_comb begin
      vpn_sel = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (LVL_W'(k) == lvl) vpn_sel = vpn[k];
      end
   end

   assign pte_addr = {base_ppn, {OFS_W{1'b0}}} + (PA_W'(vpn_sel) << SH);

   // superpage: index fields below the leaf level take the place of page-number fields
   for (genvar j = 0; j < LEVELS - 1; j++) begin : g_pa
      assign pa_ppn[j*VPN_W +: VPN_W] =
         (lvl > LVL_W'(j)) ? vpn[j] : leaf_ppn[j*VPN_W +: VPN_W];
   end
   assign pa_ppn[PPN_W-1:TOP_LSB] = leaf_ppn[PPN_W-1:TOP_LSB];

   assign leaf_pa = {pa_ppn, va[OFS_W-1:0]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int SCHEME = 0,
   localparam int LEVELS    = (SCHEME == 0) ? 2 : 3,
   localparam int VPN_W     = (SCHEME == 0) ? 10 : 9,
   localparam int PTE_BYTES = (SCHEME == 0) ? 4 : 8,
   localparam int PPN_W     = (SCHEME == 0) ? 22 : 44,
   localparam int PTE_W     = PTE_BYTES * 8,
   localparam int VA_W      = OFS_W + LEVELS * VPN_W,
   localparam int PA_W      = OFS_W + PPN_W,
   localparam int LVL_W     = $clog2(LEVELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic [1:0]       req_kind,
   input  logic             req_user,
   input  logic [PPN_W-1:0] root_ppn,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_pa,
   output logic [2:0]       rsp_outcome,
   output logic             mem_req,
   input  logic             mem_gnt,
   output logic             mem_we,
   output logic [PA_W-1:0]  mem_addr,
   output logic [PTE_W-1:0] mem_wdata,
   output logic             mem_lock,
   input  logic             mem_rvalid,
   input  logic [PTE_W-1:0] mem_rdata,
   input  logic             mem_err
);
   if (!(SCHEME == 0 || SCHEME == 1)) begin : g_bad_scheme
      $error("pt_walker: SCHEME must be 0 or 1");
   end
   if (PPN_W <= (LEVELS - 1) * VPN_W) begin : g_bad_ppn
      $error("pt_walker: page number narrower than the index fields");
   end

   walk_st_e         st;
   logic [VA_W-1:0]  va_q;
   logic [1:0]       kind_q;
   logic             user_q;
   logic [PPN_W-1:0] base_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PTE_W-1:0] wb_q;
   logic [PA_W-1:0]  pa_q;
   logic [2:0]       out_q;

   logic             e_invalid, e_leaf, e_perm, e_upd;
   logic [PTE_W-1:0] e_upd_pte;
   logic [PA_W-1:0]  pte_addr, leaf_pa;

   ptw_pte_check #(.PTE_W(PTE_W)) u_check (
      .pte        (mem_rdata),
      .kind       (kind_q),
      .user       (user_q),
      .invalid    (e_invalid),
      .leaf       (e_leaf),
      .perm_fault (e_perm),
      .need_upd   (e_upd),
      .upd_pte    (e_upd_pte)
   );

   ptw_addr_gen #(
      .LEVELS    (LEVELS),
      .VPN_W     (VPN_W),
      .PPN_W     (PPN_W),
      .PTE_BYTES (PTE_BYTES)
   ) u_addr (
      .va       (va_q),
      .base_ppn (base_q),
      .lvl      (lvl_q),
      .leaf_ppn (mem_rdata[PPN_LSB +: PPN_W]),
      .pte_addr (pte_addr),
      .leaf_pa  (leaf_pa)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         va_q   <= '0;
         kind_q <= '0;
         user_q <= 1'b0;
         base_q <= '0;
         lvl_q  <= '0;
         wb_q   <= '0;
         pa_q   <= '0;
         out_q  <= 3'b001;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               va_q   <= req_va;
               kind_q <= req_kind;
               user_q <= req_user;
               base_q <= root_ppn;
               lvl_q  <= LVL_W'(LEVELS - 1);
               pa_q   <= '0;
               st     <= ST_RD_REQ;
            end
            ST_RD_REQ: if (mem_gnt) st <= ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) begin
               if (mem_err) begin
                  out_q <= 3'b100;
                  st    <= ST_DONE;
               end else if (e_invalid) begin
                  out_q <= 3'b010;
                  st    <= ST_DONE;
               end else if (e_leaf) begin
                  pa_q <= leaf_pa;
                  if (e_perm) begin
                     out_q <= 3'b010;
                     st    <= ST_DONE;
                  end else if (e_upd) begin
                     wb_q <= e_upd_pte;
                     st   <= ST_WB_REQ;
                  end else begin
                     out_q <= 3'b001;
                     st    <= ST_DONE;
                  end
               end else if (lvl_q == '0) begin
                  out_q <= 3'b010;
                  st    <= ST_DONE;
               end else begin
                  base_q <= mem_rdata[PPN_LSB +: PPN_W];
                  lvl_q  <= lvl_q - 1'b1;
                  st     <= ST_RD_REQ;
               end
            end
            ST_WB_REQ: if (mem_gnt) st <= ST_WB_WAIT;
            ST_WB_WAIT: if (mem_rvalid) begin
               out_q <= mem_err ? 3'b100 : 3'b001;
               st    <= ST_DONE;
            end
            ST_DONE: if (rsp_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (st == ST_IDLE);
   assign rsp_valid   = (st == ST_DONE);
   assign rsp_outcome = out_q;
   assign rsp_pa      = out_q[OUT_OK] ? pa_q : '0;
   assign mem_req     = (st == ST_RD_REQ) || (st == ST_WB_REQ);
   assign mem_we      = (st == ST_WB_REQ);
   assign mem_addr    = pte_addr;
   assign mem_wdata   = wb_q;
   assign mem_lock    = (st == ST_RD_REQ) || (st == ST_RD_WAIT) ||
                        (st == ST_WB_REQ) || (st == ST_WB_WAIT);
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
   import ptw_pkg::*;
#(
   parameter int PA_W  = 34,
   parameter int PTE_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [PA_W-1:0]  rsp_pa,
   input logic [2:0]       rsp_outcome,
   input logic             mem_req,
   input logic             mem_gnt,
   input logic             mem_we,
   input logic [PA_W-1:0]  mem_addr,
   input logic [PTE_W-1:0] mem_wdata,
   input logic             mem_lock
);
   // R10
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones(rsp_outcome) == 1);

   // R10
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_outcome) && $stable(rsp_pa));

   // R10
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R8
   wb_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> $past(mem_lock));

   // R8
   gnt_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R6
   wb_sets_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[B_A]);

   // R9
   fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_outcome[OUT_OK] |-> rsp_pa == '0);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .rsp_ready   (rsp_ready),
   .rsp_pa      (rsp_pa),
   .rsp_outcome (rsp_outcome),
   .mem_req     (mem_req),
   .mem_gnt     (mem_gnt),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_lock    (mem_lock)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [31:0] va;
      logic [1:0]  kind;
      logic        user;
      logic [2:0]  out;
      logic [33:0] pa;
      logic [1:0]  nrd;
      logic        wb;
      logic [33:0] wb_addr;
      logic [31:0] wb_data;
   } vec_t;

   localparam logic [2:0] OK = 3'b001, PF = 3'b010, AF = 3'b100;

   localparam vec_t VECS [0:14] = '{
      '{32'h00400ABC, 2'd0, 1'b0, OK, 34'h012345ABC, 2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00400ABC, 2'd1, 1'b0, OK, 34'h012345ABC, 2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00400ABC, 2'd2, 1'b0, PF, 34'h0,         2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00400ABC, 2'd0, 1'b1, PF, 34'h0,         2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00401010, 2'd0, 1'b0, OK, 34'h000111010, 2'd2, 1'b1, 34'h000200004, 32'h00044443},
      '{32'h00401010, 2'd1, 1'b0, PF, 34'h0,         2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00402FFF, 2'd1, 1'b0, OK, 34'h000222FFF, 2'd2, 1'b1, 34'h000200008, 32'h000888C7},
      '{32'h00402FFF, 2'd0, 1'b0, OK, 34'h000222FFF, 2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00403000, 2'd2, 1'b1, OK, 34'h000333000, 2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00403000, 2'd2, 1'b0, PF, 34'h0,         2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00404000, 2'd0, 1'b0, PF, 34'h0,         2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00405000, 2'd0, 1'b0, PF, 34'h0,         2'd2, 1'b0, 34'h0, 32'h0},
      '{32'h00955123, 2'd0, 1'b0, OK, 34'h000555123, 2'd1, 1'b0, 34'h0, 32'h0},
      '{32'h00C00000, 2'd0, 1'b0, PF, 34'h0,         2'd1, 1'b0, 34'h0, 32'h0},
      '{32'h01000000, 2'd2, 1'b0, PF, 34'h0,         2'd1, 1'b0, 34'h0, 32'h0}
   };
   // requirement covered by each row
   localparam string VREQ [0:14] = '{"R9", "R5", "R5", "R5", "R6", "R5", "R6", "R6",
                                     "R5", "R5", "R4", "R3", "R9", "R3", "R3"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0;
   logic [21:0] root_ppn = 22'h100;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [33:0] rsp_pa;
   logic [2:0]  rsp_outcome;
   logic        mem_req;
   logic        mem_gnt = 1'b1;
   logic        mem_we;
   logic [33:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_lock;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_err = 1'b0;

   pt_walker u_pt_walker (
      .clk, .rst_n, .req_valid, .req_ready, .req_va, .req_kind, .req_user,
      .root_ppn, .rsp_valid, .rsp_ready, .rsp_pa, .rsp_outcome,
      .mem_req, .mem_gnt, .mem_we, .mem_addr, .mem_wdata, .mem_lock,
      .mem_rvalid, .mem_rdata, .mem_err
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   logic [31:0] mem_m [logic [33:0]];
   int          n_rd, n_wb, lock_err, err_rd_at;
   bit          err_wr, stall_mode, gap;
   logic [33:0] wb_addr_seen;
   logic [31:0] wb_data_seen;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic init_mem();
      mem_m.delete();
      mem_m[34'h100004] = 32'h00080001;   // pointer to table at 0x200
      mem_m[34'h100008] = 32'h001FFCCF;   // superpage leaf, page number 0x7FF
      mem_m[34'h10000C] = 32'h0;          // invalid
      mem_m[34'h100010] = 32'h00000005;   // W without R
      mem_m[34'h200000] = 32'h048D14C7;   // RW, A, D
      mem_m[34'h200004] = 32'h00044403;   // R only, A clear
      mem_m[34'h200008] = 32'h00088847;   // RW, A set, D clear
      mem_m[34'h20000C] = 32'h000CCCD9;   // X, user, A, D
      mem_m[34'h200010] = 32'h00155401;   // pointer at level 0
      mem_m[34'h200014] = 32'h0;          // invalid
   endtask

   // memory responder: one response per granted transfer, one cycle later
   initial begin
      bit          pend = 0;
      logic [31:0] pdata = '0;
      bit          perr = 0;
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         mem_err    = 1'b0;
         if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = pdata;
            mem_err    = perr;
            pend       = 0;
         end
         if (!mem_lock) gap = 1;
         mem_gnt = stall_mode ? ~mem_gnt : 1'b1;
         if (mem_req && mem_gnt) begin
            if (!mem_lock) lock_err++;
            pend = 1;
            if (mem_we) begin
               if (gap) lock_err++;
               perr = err_wr;
               n_wb++;
               wb_addr_seen = mem_addr;
               wb_data_seen = mem_wdata;
               if (!err_wr) mem_m[mem_addr] = mem_wdata;
               pdata = '0;
            end else begin
               perr  = (n_rd == err_rd_at);
               pdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'h0;
               n_rd++;
               gap = 0;
            end
         end
      end
   end

   task automatic clear_counts();
      n_rd = 0;
      n_wb = 0;
      wb_addr_seen = '0;
      wb_data_seen = '0;
   endtask

   task automatic send_req(input logic [31:0] va, input logic [1:0] kind, input logic user);
      req_va    = va;
      req_kind  = kind;
      req_user  = user;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(output logic [2:0] out, output logic [33:0] pa);
      while (!rsp_valid) @(negedge clk);
      out = rsp_outcome;
      pa  = rsp_pa;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0]  out;
      logic [33:0] pa;
      lock_err = 0; err_rd_at = -1; err_wr = 0; stall_mode = 0; gap = 0;
      clear_counts();
      init_mem();

      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", req_ready, 1, "req_ready in reset");
      check("R1", {rsp_valid, mem_req, mem_lock}, 0, "valid/req/lock in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", {req_ready, rsp_valid, mem_req, mem_lock}, 4'b1000, "idle after reset");

      // vector table
      for (int i = 0; i < 15; i++) begin
         init_mem();
         clear_counts();
         send_req(VECS[i].va, VECS[i].kind, VECS[i].user);
         wait_rsp(out, pa);
         check(VREQ[i], out, VECS[i].out, $sformatf("outcome row %0d", i));
         check("R9", pa, VECS[i].pa, $sformatf("pa row %0d", i));
         check("R2", n_rd, VECS[i].nrd, $sformatf("reads row %0d", i));
         check("R6", n_wb, VECS[i].wb, $sformatf("write-backs row %0d", i));
         if (VECS[i].wb) begin
            check("R6", wb_addr_seen, VECS[i].wb_addr, $sformatf("wb addr row %0d", i));
            check("R6", wb_data_seen, VECS[i].wb_data, $sformatf("wb data row %0d", i));
         end
      end

      // R7 error on the write-back
      init_mem(); clear_counts(); err_wr = 1;
      send_req(32'h00401010, 2'd0, 1'b0);
      wait_rsp(out, pa);
      check("R7", out, AF, "write-back error outcome");
      check("R7", pa, 0, "write-back error pa");
      err_wr = 0;

      // R7 error on the second entry read
      init_mem(); clear_counts(); err_rd_at = 1;
      send_req(32'h00400ABC, 2'd0, 1'b0);
      wait_rsp(out, pa);
      check("R7", out, AF, "read error outcome");
      check("R7", n_wb, 0, "no write-back after read error");
      err_rd_at = -1;

      // R8 grant stalls during a walk with write-back
      init_mem(); clear_counts(); stall_mode = 1;
      send_req(32'h00402FFF, 2'd1, 1'b0);
      wait_rsp(out, pa);
      check("R8", out, OK, "outcome under grant stall");
      check("R8", mem_m[34'h200008], 32'h000888C7, "entry after stalled write-back");
      stall_mode = 0;
      mem_gnt = 1'b1;

      // R10 result back-pressure with a new request waiting
      init_mem(); clear_counts(); rsp_ready = 1'b0;
      send_req(32'h00400ABC, 2'd0, 1'b0);
      while (!rsp_valid) @(negedge clk);
      req_va = 32'h00403000; req_kind = 2'd2; req_user = 1'b1; req_valid = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check("R10", {rsp_valid, req_ready}, 2'b10, "held result blocks accept");
         check("R10", {rsp_outcome, rsp_pa}, {OK, 34'h012345ABC}, "held result stable");
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      check("R10", req_ready, 1, "ready after result taken");
      @(negedge clk);
      req_valid = 1'b0;
      wait_rsp(out, pa);
      check("R10", {out, pa}, {OK, 34'h000333000}, "queued request result");

      // R8 lock discipline over the whole run
      check("R8", lock_err, 0, "requests without lock");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule